// File: doc/BRIEF.md
# Event-Gated Performance Counter Bank

This block holds a small bank of event counters for a processor core. Each counter is tied, by a selection code, to one bit of a vector of single-cycle event strobes (elapsed cycles, retired instructions, taken branches, cache misses, stalls and so on). The counters only move while a measurement window is open. The window covers either the whole time the core is running, or an interval bounded by two ordered break-condition match pulses, in either order.

The counters run off the core clock enable, so they freeze whenever the core clock is stopped, for example in sleep. A branch event adds two instead of one. A counter that would pass its maximum value saturates at all ones and raises a sticky overflow flag, so software sees an overflow indication rather than a wrapped value. A single clear command zeroes every counter, drops every flag and re-arms the window. A configuration write that sets a break-bounded window with no counter enabled is refused and raises an error flag. Values are read through an indexed read port.

Top module: `perf_counter_bank`

## Requirements
- R1: After synchronous reset all counters read zero, all overflow flags and `cfg_err` are low, the window mode is "while running" (code 0) and every selection is zero.
- R2: Counter i takes selection field `cfg_sel[i*SEL_W +: SEL_W]`. Code 0, or any code above NUM_EVT, leaves the counter unchanged. Code k in 1..NUM_EVT adds to the counter in each clock where `evt_strobe[k-1]` is high while the window is active.
- R3: The increment is 1, except for selection code BRANCH_SEL (default 3), which adds 2 per strobe.
- R4: In mode 0 the window is active in every cycle where `run` is high.
- R5: In mode 1 the window opens after a `cond1_hit` cycle, so counting starts on the following cycle. It closes after a `cond2_hit` cycle, which is still counted. Once closed it stays closed until it is re-armed. While open, counting also requires `run`.
- R6: Mode 2 behaves like mode 1 with the roles swapped: `cond2_hit` opens the window and `cond1_hit` closes it.
- R7: A close pulse that arrives while the window is armed but not yet open is ignored. When the open and close pulses fall in the same armed cycle, the window opens.
- R8: While `clk_en` is low, no counter advances and the window state does not change.
- R9: An increment that would take a counter above 2^CNT_W-1 instead sets it to all ones and sets its overflow flag. That counter then holds until a clear.
- R10: `clr` zeroes all counters and overflow flags and re-arms the window. It overrides any event in the same cycle.
- R11: A configuration write (`cfg_we`) with mode 3, or with mode 1 or 2 and every selection zero, is refused: the previous configuration stays and `cfg_err` goes high. An accepted write applies the mode and selections from the next cycle, clears `cfg_err` and re-arms the window. Counter values are not touched.
- R12: `rd_value` and `rd_ovf` show counter `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Core clock running; low models a stopped clock |
| run | input | 1 | Core is executing |
| cond1_hit | input | 1 | Break condition 1 match pulse |
| cond2_hit | input | 1 | Break condition 2 match pulse |
| evt_strobe | input | NUM_EVT | One-cycle event strobes |
| clr | input | 1 | Clear all counters and flags, re-arm window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Window mode: 0 run, 1 cond1-to-cond2, 2 cond2-to-cond1 |
| cfg_sel | input | NUM_CNT*SEL_W | Packed event selection per counter |
| cfg_err | output | 1 | Last configuration write was refused |
| rd_idx | input | IDX_W | Counter to read |
| rd_value | output | CNT_W | Selected counter value |
| rd_ovf | output | 1 | Selected counter overflow flag |

## Verification
The collisions that matter are open and close pulses in the same armed cycle, and a clear or configuration write in a cycle where strobes would otherwise count. The bench drives each of these in a directed step and also lets them land at random in a long mixed run. A behavioural model steps alongside the design with plain integers and a window-state number. Every counter, flag and the error bit are compared through the read port after every clock, so whichever function wins shows up in the very next comparison.

// File: rtl/perf_pkg.sv
`timescale 1ns/1ps
package perf_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_C1C2 = 2'd1,
        MODE_C2C1 = 2'd2,
        MODE_BAD  = 2'd3
    } win_mode_e;

    typedef enum logic [1:0] {
        WIN_ARMED = 2'd0,
        WIN_OPEN  = 2'd1,
        WIN_DONE  = 2'd2
    } win_state_e;

    typedef struct packed {
        logic open_hit;
        logic close_hit;
    } win_ctl_t;

    function automatic logic [1:0] evt_step(input logic is_branch);
        return is_branch ? 2'd2 : 2'd1;
    endfunction

    function automatic logic cfg_refused(input logic [1:0] mode, input logic any_sel);
        return (mode == MODE_BAD) || ((mode != MODE_RUN) && !any_sel);
    endfunction

endpackage

// File: rtl/perf_cfg.sv
`timescale 1ns/1ps
module perf_cfg
    import perf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int SEL_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_mode,
    input  logic [NUM_CNT*SEL_W-1:0] cfg_sel,
    output win_mode_e                mode_q,
    output logic [NUM_CNT*SEL_W-1:0] sel_q,
    output logic                     err_q,
    output logic                     accept
);
    logic refuse;

    always_comb begin
        refuse = cfg_refused(cfg_mode, |cfg_sel);
        accept = cfg_we && !refuse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            sel_q  <= '0;
            err_q  <= 1'b0;
        end else if (cfg_we) begin
            if (refuse) begin
                err_q <= 1'b1;
            end else begin
                mode_q <= win_mode_e'(cfg_mode);
                sel_q  <= cfg_sel;
                err_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/perf_window.sv
`timescale 1ns/1ps
module perf_window
    import perf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       run,
    input  logic       rearm,
    input  win_mode_e  mode,
    input  logic       cond1_hit,
    input  logic       cond2_hit,
    output win_state_e state_q,
    output logic       active
);
    win_ctl_t   ctl;
    win_state_e state_d;

    always_comb begin
        ctl.open_hit  = (mode == MODE_C2C1) ? cond2_hit : cond1_hit;
        ctl.close_hit = (mode == MODE_C2C1) ? cond1_hit : cond2_hit;
        state_d = state_q;
        if (rearm) begin
            state_d = WIN_ARMED;
        end else if (clk_en && mode != MODE_RUN) begin
            case (state_q)
                WIN_ARMED: if (ctl.open_hit)  state_d = WIN_OPEN;
                WIN_OPEN:  if (ctl.close_hit) state_d = WIN_DONE;
                default:   state_d = state_q;
            endcase
        end
        active = clk_en && run && ((mode == MODE_RUN) || (state_q == WIN_OPEN));
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WIN_ARMED;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/perf_counter.sv
`timescale 1ns/1ps
module perf_counter
    import perf_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_EVT    = 8,
    parameter int SEL_W      = 4,
    parameter int BRANCH_SEL = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               active,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               ovf_q
);
    localparam int EXT_W = 2 ** SEL_W;

    logic [EXT_W-1:0] ext;
    logic             hit;
    logic [CNT_W:0]   sum;

    always_comb begin
        ext = '0;
        ext[NUM_EVT:1] = evt_strobe;
        hit = ext[sel];
        sum = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, evt_step(sel == SEL_W'(BRANCH_SEL))};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (!ovf_q && active && hit) begin
            if (sum[CNT_W]) begin
                cnt_q <= '1;
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= sum[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
    import perf_pkg::*;
#(
    parameter int NUM_CNT    = 4,
    parameter int CNT_W      = 32,
    parameter int NUM_EVT    = 8,
    parameter int BRANCH_SEL = 3,
    localparam int SEL_W     = $clog2(NUM_EVT + 1),
    localparam int IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  logic                     run,
    input  logic                     cond1_hit,
    input  logic                     cond2_hit,
    input  logic [NUM_EVT-1:0]       evt_strobe,
    input  logic                     clr,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_mode,
    input  logic [NUM_CNT*SEL_W-1:0] cfg_sel,
    output logic                     cfg_err,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [CNT_W-1:0]         rd_value,
    output logic                     rd_ovf
);
    win_mode_e                     mode_q;
    logic [NUM_CNT*SEL_W-1:0]      sel_q;
    logic                          accept;
    win_state_e                    win_state;
    logic                          active;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0]            ovf_q;

    perf_cfg #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_sel(cfg_sel), .mode_q(mode_q), .sel_q(sel_q),
        .err_q(cfg_err), .accept(accept)
    );

    perf_window u_win (
        .clk(clk), .rst(rst), .clk_en(clk_en), .run(run),
        .rearm(clr || accept), .mode(mode_q),
        .cond1_hit(cond1_hit), .cond2_hit(cond2_hit),
        .state_q(win_state), .active(active)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        perf_counter #(
            .CNT_W(CNT_W), .NUM_EVT(NUM_EVT),
            .SEL_W(SEL_W), .BRANCH_SEL(BRANCH_SEL)
        ) u_cnt (
            .clk(clk), .rst(rst), .clr(clr), .active(active),
            .sel(sel_q[i*SEL_W +: SEL_W]), .evt_strobe(evt_strobe),
            .cnt_q(cnt_q[i]), .ovf_q(ovf_q[i])
        );
    end

    always_comb begin
        rd_value = '0;
        rd_ovf   = 1'b0;
        if (32'(rd_idx) < NUM_CNT) begin
            rd_value = cnt_q[rd_idx];
            rd_ovf   = ovf_q[rd_idx];
        end
    end
endmodule

// File: rtl/perf_counter_bank_chk.sv
`timescale 1ns/1ps
module perf_counter_bank_chk
    import perf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          clk_en,
    input logic                          clr,
    input logic                          cfg_we,
    input logic [1:0]                    cfg_mode,
    input logic [NUM_CNT*SEL_W-1:0]      cfg_sel,
    input logic                          cfg_err,
    input logic [NUM_CNT*SEL_W-1:0]      sel_q,
    input win_state_e                    win_state,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_CNT-1:0]            ovf_q
);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R8
    frozen_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !clr) |=> $stable(cnt_q));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0) && (ovf_q == '0));

    // R11
    refused_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && ((cfg_mode == 2'd3) || (cfg_mode != 2'd0 && cfg_sel == '0)))
        |=> (cfg_err && $stable(sel_q)));

    // R5
    window_done_chk: assert property (@(posedge clk) disable iff (rst)
        (win_state == WIN_DONE && !clr && !cfg_we) |=> (win_state == WIN_DONE));

    // R2
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_off
        disabled_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_q[i*SEL_W +: SEL_W] == '0 && !clr) |=> $stable(cnt_q[i]));
    end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .clk_en(clk_en), .clr(clr), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_err(cfg_err),
    .sel_q(sel_q), .win_state(win_state), .cnt_q(cnt_q), .ovf_q(ovf_q)
);

// File: tb/tb_perf_counter_bank.sv
`timescale 1ns/1ps
module tb_perf_counter_bank;
    localparam int NC = 4;
    localparam int CW = 8;
    localparam int NE = 8;
    localparam int SW = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b1, run = 1'b0, c1 = 1'b0, c2 = 1'b0;
    logic [NE-1:0] evt = '0;
    logic clr = 1'b0, we = 1'b0;
    logic [1:0] wmode = 2'd0;
    logic [NC*SW-1:0] wsel = '0;
    logic cfg_err;
    logic [1:0] rd_idx = '0;
    logic [CW-1:0] rd_value;
    logic rd_ovf;

    int n_chk = 0, n_fail = 0;
    string tag = "R1";

    int mcnt[NC];
    bit movf[NC];
    int msel[NC];
    int mmode = 0, mst = 0;
    bit merr = 0;

    always #2.5 clk = ~clk;

    perf_counter_bank #(.NUM_CNT(NC), .CNT_W(CW), .NUM_EVT(NE), .BRANCH_SEL(3)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .run(run),
        .cond1_hit(c1), .cond2_hit(c2), .evt_strobe(evt), .clr(clr),
        .cfg_we(we), .cfg_mode(wmode), .cfg_sel(wsel), .cfg_err(cfg_err),
        .rd_idx(rd_idx), .rd_value(rd_value), .rd_ovf(rd_ovf)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < NC; i++) begin
            rd_idx = 2'(i);
            #0.2;
            chk(int'(rd_value) == mcnt[i], $sformatf("cnt%0d", i), int'(rd_value), mcnt[i]);
            chk(rd_ovf == movf[i], $sformatf("ovf%0d", i), int'(rd_ovf), int'(movf[i]));
        end
        chk(cfg_err == merr, "cfg_err", int'(cfg_err), int'(merr));
    endtask

    task automatic model_tick();
        bit active, op, cl, bad;
        int st;
        if (clr) begin
            for (int i = 0; i < NC; i++) begin mcnt[i] = 0; movf[i] = 0; end
            mst = 0;
        end else if (clk_en) begin
            active = run && (mmode == 0 || mst == 1);
            for (int i = 0; i < NC; i++) begin
                if (!movf[i] && active && msel[i] >= 1 && msel[i] <= NE && evt[msel[i]-1]) begin
                    st = (msel[i] == 3) ? 2 : 1;
                    if (mcnt[i] + st > MAXV) begin mcnt[i] = MAXV; movf[i] = 1; end
                    else mcnt[i] += st;
                end
            end
            op = (mmode == 2) ? c2 : c1;
            cl = (mmode == 2) ? c1 : c2;
            if (mmode != 0) begin
                if (mst == 0 && op) mst = 1;
                else if (mst == 1 && cl) mst = 2;
            end
        end
        if (we) begin
            bad = (wmode == 3) || (wmode != 0 && wsel == '0);
            if (bad) merr = 1;
            else begin
                mmode = int'(wmode);
                for (int i = 0; i < NC; i++) msel[i] = int'(wsel[i*SW +: SW]);
                merr = 0;
                mst = 0;
            end
        end
    endtask

    task automatic cyc(input bit r, input bit a, input bit b, input logic [NE-1:0] e,
                       input bit ce, input bit cl, input bit w,
                       input logic [1:0] md, input logic [NC*SW-1:0] sl);
        @(negedge clk);
        run = r; c1 = a; c2 = b; evt = e; clk_en = ce; clr = cl;
        we = w; wmode = md; wsel = sl;
        @(posedge clk);
        model_tick();
        #0.5;
        compare_all();
    endtask

    task automatic ev(input bit r, input logic [NE-1:0] e);
        cyc(r, 0, 0, e, 1, 0, 0, 2'd0, '0);
    endtask

    task automatic cfg(input logic [1:0] md, input logic [NC*SW-1:0] sl);
        cyc(0, 0, 0, '0, 1, 0, 1, md, sl);
    endtask

    task automatic clear();
        cyc(0, 0, 0, '0, 1, 1, 0, 2'd0, '0);
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog expired in %s actual=0 expected=1", tag);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin mcnt[i] = 0; movf[i] = 0; msel[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.5;
        tag = "R1"; compare_all();

        // R2 R3 R4 R12: counters 0..3 select events 1,3(branch),0(off),5
        tag = "R2";
        cfg(2'd0, {4'd5, 4'd0, 4'd3, 4'd1});
        for (int k = 0; k < 40; k++) ev(k % 7 != 0, NE'($urandom));
        tag = "R3";
        for (int k = 0; k < 6; k++) ev(1, 8'b0000_0100);
        tag = "R4";
        for (int k = 0; k < 6; k++) ev(0, 8'hFF);

        // R8 stopped clock
        tag = "R8";
        for (int k = 0; k < 8; k++) cyc(1, 0, 0, 8'hFF, 0, 0, 0, 2'd0, '0);

        // R9 saturation: counter1 (+2) hits FE+2, counter0 hits FF+1
        tag = "R9";
        clear();
        for (int k = 0; k < 262; k++) ev(1, 8'hFF);

        // R10 clear beats strobes in same cycle
        tag = "R10";
        cyc(1, 0, 0, 8'hFF, 1, 1, 0, 2'd0, '0);
        ev(1, 8'hFF);

        // R5 mode 1, with R7 early close ignored
        tag = "R5";
        clear();
        cfg(2'd1, {4'd0, 4'd2, 4'd3, 4'd1});
        tag = "R7";
        cyc(1, 0, 1, 8'hFF, 1, 0, 0, 2'd0, '0);
        ev(1, 8'hFF);
        tag = "R5";
        cyc(1, 1, 0, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 5; k++) ev(1, 8'hFF);
        cyc(1, 0, 1, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 3; k++) ev(1, 8'hFF);
        cyc(1, 1, 0, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 3; k++) ev(1, 8'hFF);

        // R6 mode 2
        tag = "R6";
        cfg(2'd2, {4'd0, 4'd2, 4'd3, 4'd1});
        cyc(1, 1, 0, 8'hFF, 1, 0, 0, 2'd0, '0);
        cyc(1, 0, 1, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 4; k++) ev(1, 8'hFF);
        cyc(1, 1, 0, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 3; k++) ev(1, 8'hFF);

        // R7 simultaneous open and close while armed
        tag = "R7";
        cfg(2'd1, {4'd0, 4'd2, 4'd3, 4'd1});
        cyc(1, 1, 1, 8'hFF, 1, 0, 0, 2'd0, '0);
        for (int k = 0; k < 3; k++) ev(1, 8'hFF);

        // R11 refused configurations
        tag = "R11";
        cfg(2'd1, '0);
        for (int k = 0; k < 2; k++) ev(1, 8'hFF);
        cfg(2'd3, {4'd1, 4'd1, 4'd1, 4'd1});
        ev(1, 8'hFF);
        cfg(2'd0, {4'd8, 4'd9, 4'd0, 4'd7});
        for (int k = 0; k < 4; k++) ev(1, 8'hFF);

        // mixed stress with collisions
        tag = "R10";
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom % 100);
            cyc($urandom % 4 != 0, $urandom % 9 == 0, $urandom % 9 == 0, NE'($urandom),
                $urandom % 6 != 0, r < 3, r >= 95, 2'($urandom),
                (r % 2 == 0) ? '0 : 16'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule